// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block tracks which operating mode a small microcontroller core is in. It follows the mode through two active speeds, a low-speed subactive mode and four halted modes: sleep at high speed, sleep at medium speed, standby and watch. A one-cycle sleep strobe from an active mode picks the halted mode from a fixed decode of four control bits. These are standby-select, low-speed-on, medium-speed-on and watch-timer-select.

Each halted mode has its own set of wake sources. Standby listens to IRQ0 and IRQ1. Watch listens to IRQ0 and timer A. The two sleep modes listen to every source. A request wakes the core only when its enable bit is set and the global interrupt mask is clear.

The block drives three outputs: the encoded mode, a CPU-halt flag and a divider shift for the CPU clock. The CPU clock equals the source clock divided by 2 to the power of the shift. The states, with their output codes, are RESET (0), ACT_HI (1), ACT_MED (2), SUBACT (3), SLP_HI (4), SLP_MED (5), STANDBY (6) and WATCH (7). The transitions are:

- reset release: RESET to ACT_HI.
- sleep entry: any active state (ACT_HI, ACT_MED, SUBACT) to SLP_HI, SLP_MED, STANDBY or WATCH.
- wake: any halted state to ACT_HI, ACT_MED or SUBACT.
- forced reset: any state to RESET.

Top module: `lpm_ctrl`

## Requirements
- R1: While rst_n is 0 the mode output is 0 (RESET), halt is 1 and the divider shift is 0, whatever the mode was before. The first clock edge after rst_n returns to 1 moves the mode to 1 (ACT_HI).
- R2: A sleep strobe sampled in an active mode (1, 2 or 3) with standby-select=1, low-speed-on=0 and watch-timer-select=0 gives mode 6 (STANDBY) after that clock edge.
- R3: A sleep strobe sampled in an active mode with standby-select=1 and watch-timer-select=1 gives mode 7 (WATCH), whatever low-speed-on is.
- R4: A sleep strobe sampled in an active mode with standby-select=0 and low-speed-on=0 gives mode 4 (SLP_HI) when medium-speed-on=0. It gives mode 5 (SLP_MED) when medium-speed-on=1. Watch-timer-select has no effect in this case.
- R5: A sleep strobe that hits any of the undecoded combinations leaves the mode unchanged. These combinations are standby-select=1 with low-speed-on=1 and watch-timer-select=0, and standby-select=0 with low-speed-on=1.
- R6: Interrupt request bit 0 is IRQ0, bit 1 is IRQ1 and bit 2 is timer A. Bits 3 and up are other sources. STANDBY wakes only on bit 0 or bit 1. WATCH wakes only on bit 0 or bit 2. SLP_HI and SLP_MED wake on any bit.
- R7: No wake occurs while the global mask is 1. A request also does not wake the core while its own enable bit is 0.
- R8: A wake goes to mode 3 (SUBACT) when low-speed-on=1. It goes to mode 2 (ACT_MED) when low-speed-on=0 and medium-speed-on=1. Otherwise it goes to mode 1 (ACT_HI). The change appears one clock edge after the request is sampled.
- R9: A sleep strobe in a halted mode is ignored. When a strobe and a qualifying wake arrive in the same cycle, the wake is served and the mode goes to the wake target.
- R10: The halt output is 1 in modes 0, 4, 5, 6 and 7. It is 0 in modes 1, 2 and 3.
- R11: In SUBACT the divider shift is 1, 2 or 3 (watch clock divided by 2, 4 or 8) for subactive field values 0, 1 and 2. A field value of 3 also gives 3.
- R12: In ACT_MED the divider shift is 4 plus the medium-speed field (0 to 3). In every other mode the shift is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | One-cycle sleep instruction strobe |
| standby_sel_i | input | 1 | Standby-select control bit |
| low_speed_i | input | 1 | Low-speed-on control bit |
| med_speed_i | input | 1 | Medium-speed-on control bit |
| watch_sel_i | input | 1 | Watch-timer-select control bit |
| int_mask_i | input | 1 | Global interrupt mask, 1 blocks every wake |
| irq_req_i | input | NUM_SRC | Interrupt requests (bit 0 IRQ0, bit 1 IRQ1, bit 2 timer A) |
| irq_en_i | input | NUM_SRC | Per-source enable bits |
| sub_div_i | input | 2 | Subactive divider field |
| med_div_i | input | 2 | Medium-speed divider field |
| mode_o | output | 3 | Current mode code |
| halt_o | output | 1 | CPU halted |
| div_shift_o | output | 3 | CPU clock divider, as a power of two |

## Verification
On every cycle, the assertions check each sleep-entry decode against the raw control bits, and check that undecoded strobes and masked wakes leave the state stable. They also check that a halted state moves only when a source in its own set is live, that RESET always leaves for ACT_HI, and that the subactive shift stays in its three-value range.

Only the bench scenarios show the full paths through the states: the wake target after each kind of sleep, sources that are ignored in one mode but serve in another, and the same-cycle race between a strobe and a wake. The bench scenarios also cover dropping out of a halted mode through reset, and the exact divider values over each field sweep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        MODE_RESET   = 3'd0,
        MODE_ACT_HI  = 3'd1,
        MODE_ACT_MED = 3'd2,
        MODE_SUBACT  = 3'd3,
        MODE_SLP_HI  = 3'd4,
        MODE_SLP_MED = 3'd5,
        MODE_STANDBY = 3'd6,
        MODE_WATCH   = 3'd7
    } lpm_mode_e;

    typedef struct packed {
        logic standby_sel;
        logic low_speed;
        logic med_speed;
        logic watch_sel;
    } lpm_ctl_t;

    function automatic logic lpm_is_active(lpm_mode_e m);
        return (m == MODE_ACT_HI) || (m == MODE_ACT_MED) || (m == MODE_SUBACT);
    endfunction

    function automatic logic lpm_is_low_power(lpm_mode_e m);
        return (m == MODE_SLP_HI) || (m == MODE_SLP_MED) ||
               (m == MODE_STANDBY) || (m == MODE_WATCH);
    endfunction

    function automatic lpm_mode_e lpm_wake_target(lpm_ctl_t c);
        if (c.low_speed)      return MODE_SUBACT;
        else if (c.med_speed) return MODE_ACT_MED;
        else                  return MODE_ACT_HI;
    endfunction

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
    import lpm_pkg::*;
#(
    parameter int NUM_SRC  = 6,
    parameter int SRC_IRQ0 = 0,
    parameter int SRC_IRQ1 = 1,
    parameter int SRC_TIMA = 2
) (
    input  lpm_mode_e          mode,
    input  logic               int_mask,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    output logic               wake
);

    localparam logic [NUM_SRC-1:0] ONE = {{(NUM_SRC-1){1'b0}}, 1'b1};
    localparam logic [NUM_SRC-1:0] STBY_SET  = (ONE << SRC_IRQ0) | (ONE << SRC_IRQ1);
    localparam logic [NUM_SRC-1:0] WATCH_SET = (ONE << SRC_IRQ0) | (ONE << SRC_TIMA);

    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] stby_hit;
    logic [NUM_SRC-1:0] watch_hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign live[i]      = irq_req[i] & irq_en[i];
        assign stby_hit[i]  = live[i] & STBY_SET[i];
        assign watch_hit[i] = live[i] & WATCH_SET[i];
    end

    logic any_hit;

    always_comb begin
        unique case (mode)
            MODE_STANDBY:              any_hit = |stby_hit;
            MODE_WATCH:                any_hit = |watch_hit;
            MODE_SLP_HI, MODE_SLP_MED: any_hit = |live;
            default:                   any_hit = 1'b0;
        endcase
        wake = any_hit & ~int_mask;
    end

    // R6: a wake from standby needs a live IRQ0 or IRQ1 request
    always_comb begin
        if (wake && mode == MODE_STANDBY)
            a_r6_standby_src: assert ((irq_req[SRC_IRQ0] & irq_en[SRC_IRQ0]) |
                                      (irq_req[SRC_IRQ1] & irq_en[SRC_IRQ1]));
    end

    // R6: a wake from watch needs a live IRQ0 or timer A request
    always_comb begin
        if (wake && mode == MODE_WATCH)
            a_r6_watch_src: assert ((irq_req[SRC_IRQ0] & irq_en[SRC_IRQ0]) |
                                    (irq_req[SRC_TIMA] & irq_en[SRC_TIMA]));
    end

    // R7: the global mask blocks every wake
    always_comb begin
        if (int_mask)
            a_r7_mask_blocks: assert (!wake);
    end

endmodule

// File: rtl/lpm_sleep_decode.sv
module lpm_sleep_decode
    import lpm_pkg::*;
(
    input  lpm_ctl_t  ctl,
    output logic      valid,
    output lpm_mode_e target
);

    always_comb begin
        valid  = 1'b1;
        target = MODE_ACT_HI;
        if (ctl.standby_sel && ctl.watch_sel) begin
            target = MODE_WATCH;
        end else if (ctl.standby_sel && !ctl.low_speed) begin
            target = MODE_STANDBY;
        end else if (!ctl.standby_sel && !ctl.low_speed) begin
            target = ctl.med_speed ? MODE_SLP_MED : MODE_SLP_HI;
        end else begin
            valid = 1'b0;
        end
    end

endmodule

// File: rtl/lpm_clk_sel.sv
module lpm_clk_sel
    import lpm_pkg::*;
#(
    parameter int DIV_W    = 2,
    parameter int SHIFT_W  = 3,
    parameter int MED_BASE = 4,
    parameter int SUB_MAX  = 3
) (
    input  lpm_mode_e          mode,
    input  logic [DIV_W-1:0]   sub_div,
    input  logic [DIV_W-1:0]   med_div,
    output logic [SHIFT_W-1:0] div_shift
);

    localparam logic [SHIFT_W-1:0] BASE_M = SHIFT_W'(MED_BASE);
    localparam logic [SHIFT_W-1:0] S_MAX  = SHIFT_W'(SUB_MAX);

    logic [SHIFT_W-1:0] sub_shift;

    always_comb begin
        sub_shift = SHIFT_W'(sub_div) + SHIFT_W'(1);
        if (sub_shift > S_MAX) sub_shift = S_MAX;
    end

    always_comb begin
        unique case (mode)
            MODE_SUBACT:  div_shift = sub_shift;
            MODE_ACT_MED: div_shift = BASE_M + SHIFT_W'(med_div);
            default:      div_shift = '0;
        endcase
    end

    // R11: the subactive shift stays within divide-by-2 .. divide-by-8
    always_comb begin
        if (mode == MODE_SUBACT)
            a_r11_sub_range: assert (div_shift >= SHIFT_W'(1) && div_shift <= S_MAX);
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_SRC  = 6,
    parameter int DIV_W    = 2,
    parameter int SHIFT_W  = 3,
    parameter int MED_BASE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_i,
    input  logic               standby_sel_i,
    input  logic               low_speed_i,
    input  logic               med_speed_i,
    input  logic               watch_sel_i,
    input  logic               int_mask_i,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic [NUM_SRC-1:0] irq_en_i,
    input  logic [DIV_W-1:0]   sub_div_i,
    input  logic [DIV_W-1:0]   med_div_i,
    output logic [2:0]         mode_o,
    output logic               halt_o,
    output logic [SHIFT_W-1:0] div_shift_o
);

    lpm_mode_e state_q, state_d;
    lpm_ctl_t  ctl;
    logic      sleep_ok;
    lpm_mode_e sleep_tgt;
    logic      wake;

    assign ctl = '{standby_sel: standby_sel_i, low_speed: low_speed_i,
                   med_speed: med_speed_i, watch_sel: watch_sel_i};

    lpm_sleep_decode u_decode (
        .ctl    (ctl),
        .valid  (sleep_ok),
        .target (sleep_tgt)
    );

    lpm_wake_qual #(.NUM_SRC(NUM_SRC)) u_wake (
        .mode     (state_q),
        .int_mask (int_mask_i),
        .irq_req  (irq_req_i),
        .irq_en   (irq_en_i),
        .wake     (wake)
    );

    lpm_clk_sel #(
        .DIV_W    (DIV_W),
        .SHIFT_W  (SHIFT_W),
        .MED_BASE (MED_BASE)
    ) u_clk (
        .mode      (state_q),
        .sub_div   (sub_div_i),
        .med_div   (med_div_i),
        .div_shift (div_shift_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_RESET:
                state_d = MODE_ACT_HI;
            MODE_ACT_HI, MODE_ACT_MED, MODE_SUBACT:
                if (sleep_i && sleep_ok) state_d = sleep_tgt;
            MODE_SLP_HI, MODE_SLP_MED, MODE_STANDBY, MODE_WATCH:
                if (wake) state_d = lpm_wake_target(ctl);
            default:
                state_d = MODE_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        mode_o = state_q;
        halt_o = !lpm_is_active(state_q);
    end

    // R1: reset always leaves for active high-speed
    a_r1_leave_reset: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == MODE_RESET |=> state_q == MODE_ACT_HI);

    // R2: standby entry
    a_r2_standby_entry: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_is_active(state_q) && sleep_i && standby_sel_i && !low_speed_i && !watch_sel_i
        |=> state_q == MODE_STANDBY);

    // R3: watch entry
    a_r3_watch_entry: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_is_active(state_q) && sleep_i && standby_sel_i && watch_sel_i
        |=> state_q == MODE_WATCH);

    // R4: sleep entry at the speed given by medium-speed-on
    a_r4_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_is_active(state_q) && sleep_i && !standby_sel_i && !low_speed_i
        |=> state_q == (med_speed_i ? MODE_SLP_MED : MODE_SLP_HI));

    // R5: undecoded strobes leave the mode alone
    a_r5_undecoded: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_is_active(state_q) && sleep_i && low_speed_i && !(standby_sel_i && watch_sel_i)
        |=> $stable(state_q));

    // R7: a masked halted mode stays put
    a_r7_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_is_low_power(state_q) && int_mask_i |=> $stable(state_q));

    // R10: the halt flag follows whether the core can execute
    a_r10_halt_active: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_is_active(state_q) && !sleep_i |=> !halt_o);

endmodule

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_i = 1'b0;
    logic       ssby = 1'b0, lson = 1'b0, mson = 1'b0, tsel = 1'b0;
    logic       imask = 1'b0;
    logic [5:0] irq = '0, en = '0;
    logic [1:0] sub_div = '0, med_div = '0;
    logic [2:0] mode;
    logic       halt;
    logic [2:0] shift;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lpm_ctrl i_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
        .standby_sel_i(ssby), .low_speed_i(lson), .med_speed_i(mson), .watch_sel_i(tsel),
        .int_mask_i(imask), .irq_req_i(irq), .irq_en_i(en),
        .sub_div_i(sub_div), .med_div_i(med_div),
        .mode_o(mode), .halt_o(halt), .div_shift_o(shift)
    );

    // {ssby,lson,mson,tsel, irq[5:0], en[5:0], imask, exp_sleep[2:0], exp_wake[2:0]}
    localparam logic [22:0] VEC [14] = '{
        {4'b0000, 6'b000001, 6'b111111, 1'b0, 3'd4, 3'd1},
        {4'b0010, 6'b100000, 6'b111111, 1'b0, 3'd5, 3'd2},
        {4'b1000, 6'b000010, 6'b111111, 1'b0, 3'd6, 3'd1},
        {4'b1000, 6'b000100, 6'b111111, 1'b0, 3'd6, 3'd6},
        {4'b1010, 6'b000001, 6'b111111, 1'b0, 3'd6, 3'd2},
        {4'b1001, 6'b000100, 6'b111111, 1'b0, 3'd7, 3'd1},
        {4'b1001, 6'b000010, 6'b111111, 1'b0, 3'd7, 3'd7},
        {4'b1101, 6'b000001, 6'b111111, 1'b0, 3'd7, 3'd3},
        {4'b1000, 6'b000001, 6'b111111, 1'b1, 3'd6, 3'd6},
        {4'b1000, 6'b000001, 6'b111110, 1'b0, 3'd6, 3'd6},
        {4'b0100, 6'b000001, 6'b111111, 1'b0, 3'd1, 3'd1},
        {4'b1100, 6'b000001, 6'b111111, 1'b0, 3'd1, 3'd1},
        {4'b0000, 6'b001000, 6'b111111, 1'b0, 3'd4, 3'd1},
        {4'b0011, 6'b000100, 6'b111111, 1'b0, 3'd5, 3'd2}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int halt_of(int m);
        return (m == 1 || m == 2 || m == 3) ? 0 : 1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sleep_i = 1'b0; irq = '0; imask = 1'b0;
        #1;
        check("R1 mode in reset", mode, 0);
        check("R1 halt in reset", halt, 1);
        step();
        rst_n = 1'b1;
        step();
        check("R1 mode after release", mode, 1);
    endtask

    task automatic do_sleep(input logic [3:0] c);
        {ssby, lson, mson, tsel} = c;
        sleep_i = 1'b1;
        step();
        sleep_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        en = 6'b111111;
        step();
        check("R1 reset mode", mode, 0);
        check("R12 shift in reset", shift, 0);
        step();
        rst_n = 1'b1;
        step();
        check("R1 first mode", mode, 1);
        check("R10 halt in ACT_HI", halt, 0);

        // R2 R3 R4 R5 R6 R7 R8: table walk
        foreach (VEC[k]) begin
            do_reset();
            do_sleep(VEC[k][22:19]);
            check($sformatf("R2-4 vec %0d sleep mode", k), mode, int'(VEC[k][5:3]));
            check($sformatf("R10 vec %0d halt", k), halt, halt_of(int'(VEC[k][5:3])));
            irq = VEC[k][18:13];
            en = VEC[k][12:7];
            imask = VEC[k][6];
            step();
            check($sformatf("R6 R7 R8 vec %0d wake mode", k), mode, int'(VEC[k][2:0]));
            irq = '0; en = 6'b111111; imask = 1'b0;
        end

        // R12: medium-speed divider sweep
        do_reset();
        do_sleep(4'b0010);
        irq = 6'b000001;
        step();
        irq = '0;
        check("R8 into ACT_MED", mode, 2);
        for (int d = 0; d < 4; d++) begin
            med_div = 2'(d);
            #1;
            check("R12 med shift", shift, 4 + d);
        end

        // R11: subactive divider sweep
        do_sleep(4'b1101);
        check("R3 watch with lson", mode, 7);
        check("R12 shift in WATCH", shift, 0);
        irq = 6'b000100;
        step();
        irq = '0;
        check("R8 into SUBACT", mode, 3);
        for (int d = 0; d < 4; d++) begin
            sub_div = 2'(d);
            #1;
            check("R11 sub shift", shift, (d > 2) ? 3 : d + 1);
        end

        // R4: sleep from subactive
        do_sleep(4'b0000);
        check("R4 sleep from SUBACT", mode, 4);

        // R9: strobe while halted is ignored
        sleep_i = 1'b1; {ssby, lson, mson, tsel} = 4'b1001;
        step();
        check("R9 strobe ignored", mode, 4);

        // R9: wake and strobe together
        irq = 6'b010000;
        {ssby, lson, mson, tsel} = 4'b0010;
        step();
        sleep_i = 1'b0; irq = '0;
        check("R9 wake wins", mode, 2);

        // R1: reset out of standby
        do_sleep(4'b1000);
        check("R2 standby again", mode, 6);
        do_reset();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule